// File: doc/BRIEF.md
# Scheduled Pin-Action Output Channel

This block drives one output pin whose level changes at a moment chosen in advance. A write port delivers a compare value and an action code. When the free-running timebase supplied from outside reaches that compare value, the channel applies the action to the pin. The compare value is either taken as written or formed inside the block from the timebase value at the time of the write plus a small written offset. A serial master uses it to produce an active-low chip select, with assert and deassert edges placed at fixed distances around each transfer.

The block holds one logical level, "active" or "inactive". A polarity input gives the pin value for the active level, and the inactive level is always its inverse. When the channel is disabled or its output is disabled, the pin shows the inactive value. An immediate mode applies the written action at the next clock edge and does not wait for a compare match. The channel holds at most one pending action.

Top module: `tpa_channel`

## Requirements
- R1: While reset is asserted, and after reset is released, the logical level is inactive, no action is pending and `match_o` is 0. The pin therefore equals `~sl_i`.
- R2: Action code 4'h9 is the "go active" action. When it is pending and `tb_i` equals the stored compare value at a clock edge, `pin_o` equals `sl_i` after that edge.
- R3: Action code 4'hA is the "go inactive" action. When it is pending and `tb_i` equals the stored compare value at a clock edge, `pin_o` equals `~sl_i` after that edge.
- R4: A scheduled write with `wr_rel_i`=1 stores `tb_i + wr_val_i` modulo 2^TB_W as the compare value, using the `tb_i` value sampled at the write edge. With `wr_rel_i`=0 it stores `wr_val_i` unchanged.
- R5: The compare is an exact equality test. A compare value the timebase has already passed produces no match until the timebase comes back to that exact value.
- R6: Only one action is pending at a time. A new accepted scheduled write replaces both the pending compare value and the pending action code.
- R7: `match_o` is 1 for exactly the one cycle after the edge at which a pending action is applied, and 0 at all other times.
- R8: An accepted write with `wr_imm_i`=1 sets the level from its action code at that edge. It discards any pending action and does not raise `match_o`.
- R9: `sl_i` gives the pin value for the active level. Changing it flips the pin at once and does not change the stored level.
- R10: When `oe_i`=0 the pin equals `~sl_i`. When `en_i`=0 the pin equals `~sl_i`, writes are ignored, and the level and any pending action are cleared.
- R11: A write whose action code is neither 4'h9 nor 4'hA is ignored. It does not change the level, and any pending action stays in place and still fires.
- R12: If an accepted write and a match fall on the same edge, the write takes effect and the old pending action is dropped without being applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tb_i | input | TB_W | Free-running timebase value |
| en_i | input | 1 | Channel enable |
| oe_i | input | 1 | Output enable |
| sl_i | input | 1 | Pin value for the active level |
| wr_i | input | 1 | Write strobe |
| wr_imm_i | input | 1 | Immediate mode for this write |
| wr_rel_i | input | 1 | Compare value is relative to the timebase |
| wr_val_i | input | TB_W | Absolute compare value or offset |
| wr_act_i | input | 4 | Action code |
| pin_o | output | 1 | Output pin |
| match_o | output | 1 | One-cycle pulse when a scheduled action is applied |

## Verification
The assertions assume that `sl_i`, `en_i` and `oe_i` are the only inputs that change the pin outside of matches and immediate writes. They also assume that the timebase value is not constrained: it may jump, stall or wrap. The stimulus changes the control inputs only between clock edges. It moves the timebase mostly in single steps, with occasional jumps, so that scheduled compare values close to the current time are hit often and passed values are checked for wrap-around. Random writes use valid, invalid, immediate and relative forms, and their compare values lie within a few counts of the timebase so that collisions between writes and matches occur.

// File: rtl/tpa_pkg.sv
package tpa_pkg;
  localparam int unsigned ACT_W = 4;

  typedef enum logic [ACT_W-1:0] {
    ACT_GO_ACTIVE   = 4'h9,
    ACT_GO_INACTIVE = 4'hA
  } act_e;

  function automatic logic act_valid(input logic [ACT_W-1:0] code);
    return (code == ACT_GO_ACTIVE) || (code == ACT_GO_INACTIVE);
  endfunction

  function automatic logic act_level(input logic [ACT_W-1:0] code);
    return code == ACT_GO_ACTIVE;
  endfunction
endpackage

// File: rtl/tpa_cmp.sv
module tpa_cmp
  import tpa_pkg::*;
#(
  parameter int unsigned TB_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [TB_W-1:0]  tb_i,
  input  logic             load_i,
  input  logic             drop_i,
  input  logic             rel_i,
  input  logic [TB_W-1:0]  val_i,
  input  logic [ACT_W-1:0] act_i,
  output logic             fire_o,
  output logic             fire_lvl_o,
  output logic             match_o
);
  logic             pend_q;
  logic [TB_W-1:0]  cmp_q;
  logic [ACT_W-1:0] act_q;
  logic [TB_W-1:0]  cmp_new;

  assign cmp_new    = rel_i ? (tb_i + val_i) : val_i;
  // an accepted write this edge wins over a match
  assign fire_o     = en_i && pend_q && !load_i && !drop_i && (tb_i == cmp_q);
  assign fire_lvl_o = act_level(act_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= 1'b0;
      cmp_q   <= '0;
      act_q   <= ACT_GO_INACTIVE;
      match_o <= 1'b0;
    end else begin
      match_o <= fire_o;
      if (!en_i || drop_i || fire_o) begin
        pend_q <= 1'b0;
      end else if (load_i) begin
        pend_q <= 1'b1;
        cmp_q  <= cmp_new;
        act_q  <= act_i;
      end
    end
  end
endmodule

// File: rtl/tpa_lvl.sv
module tpa_lvl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic oe_i,
  input  logic sl_i,
  input  logic set_i,
  input  logic set_lvl_i,
  output logic pin_o
);
  logic lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      lvl_q <= 1'b0;
    else if (!en_i)   lvl_q <= 1'b0;
    else if (set_i)   lvl_q <= set_lvl_i;
  end

  // inactive level is the inverse of sl_i
  assign pin_o = (en_i && oe_i && lvl_q) ? sl_i : ~sl_i;
endmodule

// File: rtl/tpa_channel.sv
module tpa_channel
  import tpa_pkg::*;
#(
  parameter int unsigned TB_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [TB_W-1:0]  tb_i,
  input  logic             en_i,
  input  logic             oe_i,
  input  logic             sl_i,
  input  logic             wr_i,
  input  logic             wr_imm_i,
  input  logic             wr_rel_i,
  input  logic [TB_W-1:0]  wr_val_i,
  input  logic [ACT_W-1:0] wr_act_i,
  output logic             pin_o,
  output logic             match_o
);
  logic wr_ok, wr_sched, wr_now;
  logic fire, fire_lvl;
  logic set, set_lvl;

  assign wr_ok    = en_i && wr_i && act_valid(wr_act_i);
  assign wr_sched = wr_ok && !wr_imm_i;
  assign wr_now   = wr_ok && wr_imm_i;

  tpa_cmp #(.TB_W(TB_W)) u_cmp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .tb_i       (tb_i),
    .load_i     (wr_sched),
    .drop_i     (wr_now),
    .rel_i      (wr_rel_i),
    .val_i      (wr_val_i),
    .act_i      (wr_act_i),
    .fire_o     (fire),
    .fire_lvl_o (fire_lvl),
    .match_o    (match_o)
  );

  assign set     = wr_now || fire;
  assign set_lvl = wr_now ? act_level(wr_act_i) : fire_lvl;

  tpa_lvl u_lvl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .oe_i      (oe_i),
    .sl_i      (sl_i),
    .set_i     (set),
    .set_lvl_i (set_lvl),
    .pin_o     (pin_o)
  );
endmodule

// File: rtl/tpa_channel_chk.sv
module tpa_channel_chk
  import tpa_pkg::*;
#(
  parameter int unsigned TB_W = 24
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             oe_i,
  input logic             sl_i,
  input logic             wr_i,
  input logic             wr_imm_i,
  input logic [ACT_W-1:0] wr_act_i,
  input logic             pin_o,
  input logic             match_o
);
  a_r10_off_inactive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(en_i && oe_i) |-> pin_o == ~sl_i);

  a_r10_disabled_no_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !match_o);

  a_r7_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |=> !match_o);

  a_r8_imm_no_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && wr_i && wr_imm_i && act_valid(wr_act_i)) |=> !match_o);

  a_r2_pin_change_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($stable(sl_i) && $stable(en_i) && $stable(oe_i) && !$stable(pin_o))
      |-> (match_o || $past(wr_i && wr_imm_i)));
endmodule

bind tpa_channel tpa_channel_chk #(.TB_W(TB_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .en_i     (en_i),
  .oe_i     (oe_i),
  .sl_i     (sl_i),
  .wr_i     (wr_i),
  .wr_imm_i (wr_imm_i),
  .wr_act_i (wr_act_i),
  .pin_o    (pin_o),
  .match_o  (match_o)
);

// File: tb/tpa_channel_tb_top.sv
module tpa_channel_tb_top;
  localparam int unsigned TB_W = 24;
  localparam logic [3:0] A_ON = 4'h9, A_OFF = 4'hA;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [TB_W-1:0] tb_r = '0;
  logic en = 1'b0, oe = 1'b0, sl = 1'b0;
  logic wr = 1'b0, wr_imm = 1'b0, wr_rel = 1'b0;
  logic [TB_W-1:0] wr_val = '0;
  logic [3:0] wr_act = '0;
  logic pin, match;

  int n_chk = 0, n_fail = 0;
  logic m_lvl = 1'b0, m_pend = 1'b0, m_match = 1'b0, m_act = 1'b0;
  logic [TB_W-1:0] m_cmp = '0;

  always #2.5 clk = ~clk;

  tpa_channel #(.TB_W(TB_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tb_i(tb_r), .en_i(en), .oe_i(oe), .sl_i(sl),
    .wr_i(wr), .wr_imm_i(wr_imm), .wr_rel_i(wr_rel), .wr_val_i(wr_val),
    .wr_act_i(wr_act), .pin_o(pin), .match_o(match));

  function automatic logic exp_pin();
    return (en && oe && m_lvl) ? sl : ~sl;
  endfunction

  function automatic logic code_ok(input logic [3:0] c);
    return c == A_ON || c == A_OFF;
  endfunction

  task automatic chk(input string tag, input logic got, input logic exp, input string what);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0b expected %0b (tb=%0d)", tag, what, got, exp, tb_r);
    end
  endtask

  // model of one clock edge, inputs as currently driven
  task automatic model_edge();
    logic ok;
    ok = en && wr && code_ok(wr_act);
    m_match = 1'b0;
    if (!en) begin
      m_lvl = 0; m_pend = 0;
    end else if (ok && wr_imm) begin
      m_lvl = (wr_act == A_ON); m_pend = 0;
    end else if (ok) begin
      m_pend = 1; m_act = (wr_act == A_ON);
      m_cmp = wr_rel ? tb_r + wr_val : wr_val;
    end else if (m_pend && tb_r == m_cmp) begin
      m_lvl = m_act; m_pend = 0; m_match = 1;
    end
  endtask

  // one cycle: inputs set at negedge, edge, check at next negedge
  task automatic cyc(input string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk(tag, pin, exp_pin(), "pin_o");
    chk(tag, match, m_match, "match_o");
    wr = 0; wr_imm = 0; wr_rel = 0;
    tb_r = tb_r + 1'b1;
  endtask

  task automatic put(input logic imm, input logic rel, input logic [TB_W-1:0] v, input logic [3:0] a);
    wr = 1; wr_imm = imm; wr_rel = rel; wr_val = v; wr_act = a;
  endtask

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(tag);
  endtask

  task automatic finish_up();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_up();
  end

  initial begin
    logic [TB_W-1:0] x;
    void'($urandom(32'd4711));
    @(negedge clk);
    chk("R1", pin, 1'b1, "pin_o in reset");
    chk("R1", match, 1'b0, "match_o in reset");
    @(negedge clk);
    rst_n = 1; en = 1; oe = 1; sl = 0; tb_r = 24'd100;
    @(negedge clk);
    chk("R1", pin, 1'b1, "pin_o after reset");
    run(2, "R1");

    // R4: relative schedule, go active (R2)
    put(0, 1, 24'd5, A_ON); cyc("R4");
    run(6, "R2");
    chk("R2", pin, 1'b0, "pin_o active after relative match");
    // R3: absolute schedule, go inactive
    put(0, 0, tb_r + 24'd3, A_OFF); cyc("R3");
    run(4, "R3");
    chk("R3", pin, 1'b1, "pin_o inactive after match");
    // R4 wrap of relative sum
    tb_r = 24'hFFFFFE; put(0, 1, 24'd4, A_ON); cyc("R4");
    run(5, "R4");
    chk("R4", pin, 1'b0, "pin_o after wrapped compare");
    // R5: passed value waits for wrap
    x = tb_r - 24'd1; put(0, 0, x, A_OFF); cyc("R5");
    run(10, "R5");
    chk("R5", pin, 1'b0, "pin_o unchanged for passed value");
    tb_r = x; cyc("R5");
    chk("R5", match, 1'b1, "match_o on wrap return");
    // R6: replace pending
    put(0, 0, tb_r + 24'd2, A_ON); cyc("R6");
    put(0, 0, tb_r + 24'd6, A_ON); cyc("R6");
    run(3, "R6");
    chk("R6", pin, 1'b1, "replaced action not applied early");
    run(4, "R6");
    chk("R6", pin, 1'b0, "replacement applied");
    // R7: pulse width
    put(0, 0, tb_r + 24'd1, A_OFF); cyc("R7");
    cyc("R7"); chk("R7", match, 1'b1, "match pulse");
    cyc("R7"); chk("R7", match, 1'b0, "match pulse ends");
    // R12: write on matching edge wins
    put(0, 0, tb_r + 24'd2, A_ON); cyc("R12");
    cyc("R12");
    put(0, 0, tb_r + 24'd50, A_OFF); cyc("R12");
    chk("R12", match, 1'b0, "collision dropped old action");
    chk("R12", pin, 1'b1, "old action not applied");
    // R8: immediate write discards pending
    put(0, 0, tb_r + 24'd3, A_OFF); cyc("R8");
    put(1, 0, '0, A_ON); cyc("R8");
    chk("R8", pin, 1'b0, "immediate go active");
    chk("R8", match, 1'b0, "no match on immediate");
    run(5, "R8");
    chk("R8", pin, 1'b0, "discarded action never applied");
    // R11: invalid code ignored, pending kept
    put(0, 0, tb_r + 24'd3, A_OFF); cyc("R11");
    put(1, 0, '0, 4'h3); cyc("R11");
    chk("R11", pin, 1'b0, "invalid immediate ignored");
    put(0, 0, tb_r + 24'd40, 4'h0); cyc("R11");
    cyc("R11");
    chk("R11", match, 1'b1, "pending kept through invalid writes");
    chk("R11", pin, 1'b1, "pending applied");
    // R9: polarity
    put(1, 0, '0, A_ON); cyc("R9");
    sl = 1; #1; chk("R9", pin, 1'b1, "active with sl_i=1");
    cyc("R9");
    put(1, 0, '0, A_OFF); cyc("R9");
    chk("R9", pin, 1'b0, "inactive with sl_i=1");
    sl = 0; cyc("R9");
    // R10: output and channel disable
    put(1, 0, '0, A_ON); cyc("R10");
    oe = 0; #1; chk("R10", pin, 1'b1, "oe_i=0 inactive");
    oe = 1; #1; chk("R10", pin, 1'b0, "level kept over oe_i");
    put(0, 0, tb_r + 24'd3, A_OFF); cyc("R10");
    en = 0; put(1, 0, '0, A_ON); cyc("R10");
    run(4, "R10");
    en = 1; run(2, "R10");
    chk("R10", pin, 1'b1, "disable cleared level");
    chk("R10", match, 1'b0, "disable cleared pending");

    // random phase
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 3) tb_r = $urandom();
      else if (r < 5) tb_r = tb_r - 24'($urandom_range(1, 4));
      if ($urandom_range(0, 99) < 2) sl = ~sl;
      if ($urandom_range(0, 99) < 2) oe = ~oe;
      if ($urandom_range(0, 99) < 1) en = ~en;
      if (!en && $urandom_range(0, 9) < 3) en = 1;
      if ($urandom_range(0, 99) < 20) begin
        logic [3:0] a;
        a = ($urandom_range(0, 9) < 8) ? (($urandom_range(0, 1) != 0) ? A_ON : A_OFF)
                                       : 4'($urandom_range(0, 15));
        if ($urandom_range(0, 1) != 0)
          put($urandom_range(0, 9) < 2, 1'b1, 24'($urandom_range(0, 8)), a);
        else
          put($urandom_range(0, 9) < 2, 1'b0, tb_r + 24'($urandom_range(0, 8)), a);
      end
      cyc("R2");
    end
    finish_up();
  end
endmodule